// File: doc/BRIEF.md
# Debug State Entry Controller

This block decides when a small pipelined processor stops normal execution and enters a halted debug state. It watches an external breakpoint line and an external debug request line, both asynchronous. It also watches internal breakpoint hits (on instruction fetches) and watchpoint hits (on data accesses), qualified by a two-bit external condition. Pipeline tracking inputs describe each memory access and the instruction sitting in execute. These are a fetch tag, an execute-stage tag, an instruction-complete pulse, a flush pulse, and a fetch/data flag.

The timing of entry depends on the cause. A breakpointed fetch is remembered by its tag. The halt happens only when that tag reaches the execute stage, and a pipeline flush discards the tag. A breakpointed data access, or a debug request, halts at the next instruction completion. The block enters debug state once, records which cause won, and holds the core halted until a one-cycle restart pulse arrives. A static enable level switches the whole function off.

The external request source must drop its request on the edge where acknowledge rises. A sticky flag reports a request that is still high one cycle later.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While reset is high and right after it, `dbg_ack`, `halt_req` and `req_err` are 0 and `cause` is 0.
- R2: A fetch (`acc_valid`=1, `acc_fetch`=1) made while the synchronized external breakpoint is high marks its `fetch_tag`. In the cycle after `ex_valid`=1 shows that tag in `ex_tag`, `dbg_ack` is 1 and `cause` is 0. An execute-stage tag that was never marked causes no entry.
- R3: A `flush` pulse discards every marked fetch tag, so a later `ex_valid` with that tag causes no entry.
- R4: A data access (`acc_valid`=1, `acc_fetch`=0) made while the synchronized external breakpoint is high does not halt on its own. `dbg_ack` rises in the cycle after the next `insn_done` pulse, with `cause`=1.
- R5: While the synchronized debug request is high, `dbg_ack` rises in the cycle after an `insn_done` pulse, with `cause`=2. With no `insn_done`, there is no entry.
- R6: An internal hit (`ibp_hit` on a fetch, `wp_hit` on a data access) counts only when its 2-bit programmed condition equals `ext_cond`. When it counts, it acts exactly like the external breakpoint on that access.
- R7: When several causes qualify in the same cycle, the block enters once and `cause` takes the lowest code among them: instruction breakpoint 0, then data breakpoint/watchpoint 1, then request 2. `cause` stays stable while in debug state.
- R8: `halt_req` always equals `dbg_ack`. Both stay 1 until a `restart` pulse, which clears them on the next edge. Entry and restart both clear all pending marks.
- R9: While `dbg_en` is 0, no cause leads to entry, and `dbg_ack` is 0 from the next edge on.
- R10: If `ext_req` is still 1 on the edge one cycle after `dbg_ack` rose, `req_err` becomes 1 and stays 1 until `restart`. A request dropped on the rising edge leaves `req_err` at 0.
- R11: `ext_brk` and `ext_req` pass through a two-flop synchronizer. A change seen at one clock edge takes effect on logic from the second edge after it, so a breakpoint raised only one edge before an access does not mark it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_en | input | 1 | Static debug enable level |
| ext_brk | input | 1 | Asynchronous external breakpoint |
| ext_req | input | 1 | Asynchronous external debug request |
| ext_cond | input | 2 | External condition for hit qualification |
| ibp_hit | input | 1 | Internal breakpoint hit on the current fetch |
| ibp_cond | input | 2 | Condition programmed for the breakpoint |
| wp_hit | input | 1 | Internal watchpoint hit on the current data access |
| wp_cond | input | 2 | Condition programmed for the watchpoint |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| fetch_tag | input | TAG_W | Tag of the instruction being fetched |
| ex_valid | input | 1 | An instruction occupies the execute stage |
| ex_tag | input | TAG_W | Tag of the instruction in execute |
| insn_done | input | 1 | Pulse: current instruction completed |
| flush | input | 1 | Pulse: fetched instructions discarded |
| restart | input | 1 | Pulse: leave debug state |
| dbg_ack | output | 1 | High while in debug state |
| halt_req | output | 1 | Halt request to the core |
| cause | output | 2 | Recorded entry cause (0 instr, 1 data, 2 request) |
| req_err | output | 1 | Sticky request-handshake violation |

## Verification
Each entry path is tried with a matching and a non-matching stimulus. Fetch tags are compared against a wrong execute tag and against a flushed tag. Data hits are checked before and after completion, and requests with and without a completion pulse. This separates tag-based from completion-based timing. A full sweep of programmed condition against external condition for both hit kinds shows that qualification is an exact match, not a bit test. A sweep over all eight combinations of simultaneous causes pins down the one-time entry and the cause priority. Further runs cover a late request drop against an on-time one, a disabled block, and a breakpoint raised one edge too late, which shows the synchronizer delay.

// File: rtl/dbg_entry_pkg.sv
`timescale 1ns/1ps
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_IBRK = 2'd0,
    CAUSE_DBRK = 2'd1,
    CAUSE_EREQ = 2'd2
  } cause_e;

  // A hit counts only on an exact match of programmed and external condition
  function automatic logic cond_ok(input logic [1:0] prog, input logic [1:0] ext);
    return prog == ext;
  endfunction

  // Lowest code wins among causes qualifying together
  function automatic cause_e pick_cause(input logic i_ev, input logic d_ev);
    if (i_ev) return CAUSE_IBRK;
    if (d_ev) return CAUSE_DBRK;
    return CAUSE_EREQ;
  endfunction
endpackage

// File: rtl/dbg_sync.sv
`timescale 1ns/1ps
module dbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dbg_tag_track.sv
`timescale 1ns/1ps
module dbg_tag_track #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             use_v,
  input  logic [TAG_W-1:0] use_tag,
  output logic             hit
);
  localparam int N = 1 << TAG_W;
  logic [N-1:0] pend;

  for (genvar g = 0; g < N; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst || clr)                           pend[g] <= 1'b0;
      else if (set && set_tag == TAG_W'(g))     pend[g] <= 1'b1;
      else if (use_v && use_tag == TAG_W'(g))   pend[g] <= 1'b0;
    end
  end

  assign hit = use_v & pend[use_tag];
endmodule

// File: rtl/dbg_entry_ctrl.sv
`timescale 1ns/1ps
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int TAG_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_en,
  input  logic             ext_brk,
  input  logic             ext_req,
  input  logic [1:0]       ext_cond,
  input  logic             ibp_hit,
  input  logic [1:0]       ibp_cond,
  input  logic             wp_hit,
  input  logic [1:0]       wp_cond,
  input  logic             acc_valid,
  input  logic             acc_fetch,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             ex_valid,
  input  logic [TAG_W-1:0] ex_tag,
  input  logic             insn_done,
  input  logic             flush,
  input  logic             restart,
  output logic             dbg_ack,
  output logic             halt_req,
  output logic [1:0]       cause,
  output logic             req_err
);
  logic   brk_s, req_s;
  logic   dbg_q, ack_rose_q, err_q, dpend_q;
  cause_e cause_q;

  // named internal events
  logic arm, fetch_mark, data_mark, tag_hit;
  logic evt_ibrk, evt_dbrk, evt_ereq, enter, clr_all;

  dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_brk (
    .clk(clk), .rst(rst), .d(ext_brk), .q(brk_s));
  dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk(clk), .rst(rst), .d(ext_req), .q(req_s));

  assign arm        = dbg_en & ~dbg_q;
  assign fetch_mark = arm & acc_valid & acc_fetch &
                      (brk_s | (ibp_hit & cond_ok(ibp_cond, ext_cond)));
  assign data_mark  = arm & acc_valid & ~acc_fetch &
                      (brk_s | (wp_hit & cond_ok(wp_cond, ext_cond)));

  assign evt_ibrk = arm & tag_hit;
  assign evt_dbrk = arm & insn_done & (dpend_q | data_mark);
  assign evt_ereq = arm & insn_done & req_s;
  assign enter    = (evt_ibrk | evt_dbrk | evt_ereq) & ~restart;
  assign clr_all  = ~dbg_en | restart | enter | dbg_q;

  dbg_tag_track #(.TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_all | flush),
    .set     (fetch_mark),
    .set_tag (fetch_tag),
    .use_v   (ex_valid),
    .use_tag (ex_tag),
    .hit     (tag_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q      <= 1'b0;
      ack_rose_q <= 1'b0;
      err_q      <= 1'b0;
      dpend_q    <= 1'b0;
      cause_q    <= CAUSE_IBRK;
    end else begin
      if (!dbg_en || restart) dbg_q <= 1'b0;
      else if (enter)         dbg_q <= 1'b1;

      if (enter) cause_q <= pick_cause(evt_ibrk, evt_dbrk);

      dpend_q    <= clr_all ? 1'b0 : (dpend_q | data_mark);
      ack_rose_q <= enter;

      if (!dbg_en || restart)         err_q <= 1'b0;
      else if (ack_rose_q && ext_req) err_q <= 1'b1;
    end
  end

  assign dbg_ack  = dbg_q;
  assign halt_req = dbg_q;
  assign cause    = cause_q;
  assign req_err  = err_q;
endmodule

// File: rtl/dbg_entry_chk.sv
`timescale 1ns/1ps
module dbg_entry_chk (
  input logic       clk,
  input logic       rst,
  input logic       dbg_en,
  input logic       restart,
  input logic       flush,
  input logic       dbg_ack,
  input logic       halt_req,
  input logic [1:0] cause,
  input logic       req_err,
  input logic       evt_ibrk,
  input logic       evt_dbrk,
  input logic       evt_ereq
);
  AST_ACK_EQ_HALT: assert property (@(posedge clk) disable iff (rst)
    dbg_ack == halt_req);                                            // R8
  AST_RESTART_EXIT: assert property (@(posedge clk) disable iff (rst)
    restart |=> !dbg_ack);                                           // R8
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbg_ack && !restart && dbg_en) |=> dbg_ack);                    // R8
  AST_OFF_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !dbg_en |=> !dbg_ack);                                           // R9
  AST_ENTRY_HAS_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_ack) |-> $past(evt_ibrk || evt_dbrk || evt_ereq));     // R2
  AST_FLUSH_NO_IBRK: assert property (@(posedge clk) disable iff (rst)
    flush |=> !evt_ibrk);                                            // R3
  AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (dbg_ack && $past(dbg_ack)) |-> $stable(cause));                 // R7
  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cause != 2'd3);                                                  // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (req_err && !restart && dbg_en) |=> req_err);                    // R10
  AST_ERR_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
    req_err |-> dbg_ack);                                            // R10
endmodule

bind dbg_entry_ctrl dbg_entry_chk u_chk (
  .clk(clk), .rst(rst), .dbg_en(dbg_en), .restart(restart), .flush(flush),
  .dbg_ack(dbg_ack), .halt_req(halt_req), .cause(cause), .req_err(req_err),
  .evt_ibrk(evt_ibrk), .evt_dbrk(evt_dbrk), .evt_ereq(evt_ereq)
);

// File: tb/dbg_entry_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_tb;
  localparam int TAG_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbg_en = 1'b1, ext_brk = 1'b0, ext_req = 1'b0;
  logic [1:0] ext_cond = '0, ibp_cond = '0, wp_cond = '0;
  logic ibp_hit = 1'b0, wp_hit = 1'b0, acc_valid = 1'b0, acc_fetch = 1'b0;
  logic [TAG_W-1:0] fetch_tag = '0, ex_tag = '0;
  logic ex_valid = 1'b0, insn_done = 1'b0, flush = 1'b0, restart = 1'b0;
  logic dbg_ack, halt_req, req_err;
  logic [1:0] cause;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_entry_ctrl #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .ext_brk(ext_brk), .ext_req(ext_req),
    .ext_cond(ext_cond), .ibp_hit(ibp_hit), .ibp_cond(ibp_cond), .wp_hit(wp_hit),
    .wp_cond(wp_cond), .acc_valid(acc_valid), .acc_fetch(acc_fetch),
    .fetch_tag(fetch_tag), .ex_valid(ex_valid), .ex_tag(ex_tag),
    .insn_done(insn_done), .flush(flush), .restart(restart),
    .dbg_ack(dbg_ack), .halt_req(halt_req), .cause(cause), .req_err(req_err));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ack(input string req, input int exp);
    chk(dbg_ack == exp[0], req, dbg_ack, exp);
    chk(halt_req == dbg_ack, {req, " halt"}, halt_req, dbg_ack);
  endtask

  task automatic idle();
    ibp_hit = 0; wp_hit = 0; acc_valid = 0; acc_fetch = 0;
    ex_valid = 0; insn_done = 0; flush = 0; restart = 0;
  endtask

  task automatic do_reset();
    idle(); ext_brk = 0; ext_req = 0; dbg_en = 1; ext_cond = 0;
    ibp_cond = 0; wp_cond = 0; rst = 1;
    tick(); tick(); tick();
    rst = 0;
  endtask

  task automatic fetch(input logic [TAG_W-1:0] t, input logic ih);
    acc_valid = 1; acc_fetch = 1; fetch_tag = t; ibp_hit = ih;
    tick(); idle();
  endtask

  task automatic daccess(input logic wh);
    acc_valid = 1; acc_fetch = 0; wp_hit = wh;
    tick(); idle();
  endtask

  task automatic exec(input logic [TAG_W-1:0] t);
    ex_valid = 1; ex_tag = t;
    tick(); idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state even with inputs active
    ext_req = 1; ext_brk = 1;
    @(negedge clk); tick();
    chk(dbg_ack == 0, "R1 ack", dbg_ack, 0);
    chk(halt_req == 0, "R1 halt", halt_req, 0);
    chk(cause == 0, "R1 cause", cause, 0);
    chk(req_err == 0, "R1 err", req_err, 0);
    do_reset();
    chk_ack("R1 after release", 0);

    // R2: external breakpoint on fetch, entry on execute of that tag
    ext_brk = 1; tick(); tick();
    fetch(3'd5, 1'b0); ext_brk = 0;
    exec(3'd2);
    chk_ack("R2 wrong tag", 0);
    exec(3'd5);
    chk_ack("R2 tagged execute", 1);
    chk(cause == 0, "R2 cause", cause, 0);

    // R3: flush drops the tag
    do_reset();
    ext_brk = 1; tick(); tick();
    fetch(3'd5, 1'b0); ext_brk = 0;
    flush = 1; tick(); idle();
    exec(3'd5);
    chk_ack("R3 flushed tag", 0);

    // R4: data breakpoint waits for completion
    do_reset();
    ext_brk = 1; tick(); tick();
    daccess(1'b0); ext_brk = 0;
    tick();
    chk_ack("R4 before done", 0);
    insn_done = 1; tick(); idle();
    chk_ack("R4 after done", 1);
    chk(cause == 1, "R4 cause", cause, 1);

    // R11: breakpoint raised only one edge before the access is missed
    do_reset();
    ext_brk = 1; tick();
    daccess(1'b0); ext_brk = 0;
    insn_done = 1; tick(); idle();
    chk_ack("R11 too early", 0);

    // R5 / R10: request entry with on-time and late drop
    do_reset();
    ext_req = 1; tick(); tick(); tick();
    chk_ack("R5 no completion", 0);
    insn_done = 1; ext_req = 0; tick(); idle();
    chk_ack("R5 entry", 1);
    chk(cause == 2, "R5 cause", cause, 2);
    tick(); tick();
    chk(req_err == 0, "R10 on-time drop", req_err, 0);

    do_reset();
    ext_req = 1; tick(); tick();
    insn_done = 1; tick(); idle();
    chk_ack("R10 entry", 1);
    chk(req_err == 0, "R10 not yet", req_err, 0);
    tick();
    chk(req_err == 1, "R10 late drop", req_err, 1);
    tick();
    chk(req_err == 1, "R10 sticky", req_err, 1);
    ext_req = 0; restart = 1; tick(); idle();
    chk(req_err == 0, "R10 cleared", req_err, 0);
    chk_ack("R8 restart", 0);

    // R6: condition sweep for watchpoint and breakpoint
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 4; e++) begin
        do_reset();
        ext_cond = 2'(e); wp_cond = 2'(p);
        daccess(1'b1);
        insn_done = 1; tick(); idle();
        chk_ack($sformatf("R6 wp p=%0d e=%0d", p, e), (p == e) ? 1 : 0);
        do_reset();
        ext_cond = 2'(e); ibp_cond = 2'(p);
        fetch(3'd3, 1'b1);
        exec(3'd3);
        chk_ack($sformatf("R6 ibp p=%0d e=%0d", p, e), (p == e) ? 1 : 0);
      end
    end

    // R7 / R8: all combinations of simultaneous causes
    for (int m = 0; m < 8; m++) begin
      int exp_ack, exp_cause;
      do_reset();
      exp_ack = (m != 0) ? 1 : 0;
      exp_cause = m[0] ? 0 : (m[1] ? 1 : 2);
      if (m[2]) begin ext_req = 1; tick(); tick(); end
      if (m[0]) fetch(3'd1, 1'b1);
      if (m[1]) daccess(1'b1);
      ex_valid = 1; ex_tag = 3'd1; insn_done = 1; ext_req = 0;
      tick(); idle();
      chk_ack($sformatf("R7 combo %0d", m), exp_ack);
      if (m != 0) chk(cause == exp_cause[1:0], $sformatf("R7 cause combo %0d", m), cause, exp_cause);
      tick(); tick(); tick();
      chk_ack($sformatf("R8 hold combo %0d", m), exp_ack);
      if (m != 0) chk(cause == exp_cause[1:0], $sformatf("R7 stable combo %0d", m), cause, exp_cause);
      restart = 1; tick(); idle();
      chk_ack($sformatf("R8 exit combo %0d", m), 0);
      ex_valid = 1; ex_tag = 3'd1; insn_done = 1; tick(); idle();
      chk_ack($sformatf("R8 pending cleared combo %0d", m), 0);
    end

    // R9: disabled block ignores every cause
    do_reset();
    dbg_en = 0;
    ext_req = 1; ext_brk = 1; tick(); tick(); tick();
    fetch(3'd4, 1'b1);
    daccess(1'b1);
    ex_valid = 1; ex_tag = 3'd4; insn_done = 1; tick(); idle();
    chk_ack("R9 disabled", 0);
    tick();
    chk_ack("R9 disabled later", 0);
    chk(req_err == 0, "R9 err", req_err, 0);

    finish_run();
  end
endmodule